// File: doc/BRIEF.md
# Symmetric PWM Time-Base with Phase Synchronisation

This block is the time-base of one PWM channel. Its counter rises from zero to a programmed period and falls back to zero, one step per clock while a global run enable is high. Several instances are meant to be chained. Each instance receives a sync pulse from the previous one and passes a sync pulse on to the next. Because every instance is gated by the same run enable, all counters start on the same clock edge.

A sync event is the OR of the external sync input and a software force strobe. The strobe is honoured only while the output selector is in pass-through mode. When phase loading is enabled, a sync event writes a phase offset into the counter. The offset is clamped to the period. A direction bit picks whether counting then continues upward or downward, so a given offset lands at a chosen point of the triangle.

The sync output can do one of three things:
- repeat the sync event;
- emit a registered pulse after the counter matched a compare value;
- stay low.

A sticky flag records that a sync event arrived, whether or not a load happened.

Top module: `pwm_timebase`

## Requirements
- R1: While reset is asserted, the counter reads 0, the direction status reads 0 (up), the sync flag reads 0 and the sync output is low.
- R2: While running with a nonzero period P, the counter steps by one per clock: up from 0 to P, then down to 0, repeating. A full cycle takes 2·P clocks. A period of 0 holds the counter at 0.
- R3: While the run enable is low, the counter and the direction status hold their values, and no phase load takes place.
- R4: When the run enable and phase enable are high and a sync event occurs, the counter shows the phase value after the next clock edge. With phase enable low, a sync event leaves the counting sequence unchanged.
- R5: The loaded value is min(phase, period). After a load the direction status equals the phase-direction input (1 = down). The exception is a loaded value equal to the period, which forces down, or equal to 0, which forces up. The direction status is 1 when the most recent step was a decrement.
- R6: The sync select is 2 bits. Code 0 drives the sync output with (sync input OR software force), combinationally. Code 2 drives a pulse one clock after a cycle in which the counter equalled compare B while running. Codes 1 and 3 drive the output low.
- R7: The software force strobe is ignored when the sync select is not 0. It then sets no flag and loads no phase.
- R8: Any sync event sets the sticky sync flag on the next edge, regardless of the run and phase enables. A clear strobe resets the flag. A set in the same cycle as a clear wins.
- R9: A new period value is captured only on an edge where the counter reads 0. While the counter is nonzero, the turning point stays at the previously captured period.
- R10: A software force given in pass-through mode with phase loading enabled shows on the counter and on the sync flag one clock after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Global time-base run enable shared by chained instances |
| period_i | input | CW | Turning point of the triangle |
| phase_i | input | CW | Offset loaded on a sync event |
| phase_en_i | input | 1 | Enables phase loading |
| phase_dir_i | input | 1 | Direction after a load (1 = down) |
| cmpb_i | input | CW | Compare value for the match-driven sync output |
| sync_sel_i | input | 2 | Sync output source select |
| sw_force_i | input | 1 | One-cycle software force-sync strobe |
| sync_in_i | input | 1 | Sync pulse from the previous instance |
| flag_clr_i | input | 1 | Clears the sticky sync flag |
| counter_o | output | CW | Counter value |
| dir_down_o | output | 1 | 1 when the last step was a decrement |
| sync_flag_o | output | 1 | Sticky sync-received flag |
| sync_out_o | output | 1 | Sync pulse to the next instance |

## Verification
A wrong counter or direction state appears on `counter_o` on the very next clock. The triangle's turning points, the clamped load value and the post-load direction therefore diverge from a behavioural model within one cycle.

A stale captured period is not visible until the next peak. The bench therefore watches the peaks across a mid-cycle period change.

Errors in the sticky flag and the compare register show on `sync_flag_o` and `sync_out_o` one edge after the triggering cycle. The model checks every clock under long random stimulus. Directed cases cover clamping, the ignored software force, set-versus-clear priority and the one-cycle force latency.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;
   typedef enum logic [1:0] {
      SO_PASS  = 2'd0,
      SO_OFF_A = 2'd1,
      SO_CMPB  = 2'd2,
      SO_OFF_B = 2'd3
   } so_sel_e;
endpackage

// File: rtl/pwmtb_counter.sv
module pwmtb_counter #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  logic [CW-1:0] period_i,
   input  logic [CW-1:0] phase_i,
   input  logic          phase_dir_i,
   input  logic          load_i,
   output logic [CW-1:0] cnt_o,
   output logic          dir_down_o
);
   localparam logic [CW-1:0] ZERO = '0;
   localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

   logic [CW-1:0] cnt_q, cnt_d, prd_q, prd_eff, ld_val;
   logic          dir_q, dir_d;

   // the period register follows the input only at the bottom of the triangle
   assign prd_eff = (cnt_q == ZERO) ? period_i : prd_q;
   assign ld_val  = (phase_i > prd_eff) ? prd_eff : phase_i;

   always_comb begin
      cnt_d = cnt_q;
      dir_d = dir_q;
      if (run_i) begin
         if (load_i) begin
            cnt_d = ld_val;
            if (ld_val >= prd_eff)   dir_d = 1'b1;
            else if (ld_val == ZERO) dir_d = 1'b0;
            else                     dir_d = phase_dir_i;
         end else if (prd_eff == ZERO) begin
            cnt_d = ZERO;
         end else if (!dir_q) begin
            if (cnt_q >= prd_eff) begin
               dir_d = 1'b1;
               cnt_d = cnt_q - ONE;
            end else begin
               cnt_d = cnt_q + ONE;
            end
         end else begin
            if (cnt_q == ZERO) begin
               dir_d = 1'b0;
               cnt_d = ONE;
            end else begin
               cnt_d = cnt_q - ONE;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= ZERO;
         dir_q <= 1'b0;
         prd_q <= ZERO;
      end else begin
         cnt_q <= cnt_d;
         dir_q <= dir_d;
         if (cnt_q == ZERO) prd_q <= period_i;
      end
   end

   assign cnt_o      = cnt_q;
   assign dir_down_o = dir_q;

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= prd_q);
   // R3
   frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> ($stable(cnt_q) && $stable(dir_q)));
   // R9
   prd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != ZERO) |=> $stable(prd_q));
   // R5
   peak_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !load_i && !dir_q && cnt_q == prd_q && cnt_q != ZERO) |=> dir_q);
endmodule

// File: rtl/pwmtb_sync.sv
module pwmtb_sync
   import pwmtb_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  so_sel_e       sel_i,
   input  logic          sw_force_i,
   input  logic          sync_in_i,
   input  logic [CW-1:0] cnt_i,
   input  logic [CW-1:0] cmpb_i,
   output logic          evt_o,
   output logic          sync_out_o
);
   logic hit_q;

   assign evt_o = sync_in_i | (sw_force_i & (sel_i == SO_PASS));

   always_ff @(posedge clk) begin
      if (!rst_n) hit_q <= 1'b0;
      else        hit_q <= run_i & (cnt_i == cmpb_i);
   end

   always_comb begin
      unique case (sel_i)
         SO_PASS: sync_out_o = evt_o;
         SO_CMPB: sync_out_o = hit_q;
         default: sync_out_o = 1'b0;
      endcase
   end

   // R6
   cmpb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i == SO_CMPB && run_i && cnt_i == cmpb_i) |=> (sel_i != SO_CMPB || sync_out_o));
endmodule

// File: rtl/pwmtb_flag.sv
module pwmtb_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (set_i) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   // R8
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
   import pwmtb_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  logic [CW-1:0] period_i,
   input  logic [CW-1:0] phase_i,
   input  logic          phase_en_i,
   input  logic          phase_dir_i,
   input  logic [CW-1:0] cmpb_i,
   input  logic [1:0]    sync_sel_i,
   input  logic          sw_force_i,
   input  logic          sync_in_i,
   input  logic          flag_clr_i,
   output logic [CW-1:0] counter_o,
   output logic          dir_down_o,
   output logic          sync_flag_o,
   output logic          sync_out_o
);
   generate
      if (CW < 2 || CW > 32) begin : g_bad_width
         $error("pwm_timebase: CW must lie in 2..32");
      end
   endgenerate

   so_sel_e sel;
   logic    evt;

   assign sel = so_sel_e'(sync_sel_i);

   pwmtb_sync #(.CW(CW)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (run_i),
      .sel_i      (sel),
      .sw_force_i (sw_force_i),
      .sync_in_i  (sync_in_i),
      .cnt_i      (counter_o),
      .cmpb_i     (cmpb_i),
      .evt_o      (evt),
      .sync_out_o (sync_out_o)
   );

   pwmtb_counter #(.CW(CW)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_i       (run_i),
      .period_i    (period_i),
      .phase_i     (phase_i),
      .phase_dir_i (phase_dir_i),
      .load_i      (phase_en_i & evt),
      .cnt_o       (counter_o),
      .dir_down_o  (dir_down_o)
   );

   pwmtb_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (evt),
      .clr_i  (flag_clr_i),
      .flag_o (sync_flag_o)
   );

   // R8
   ext_sync_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_in_i |=> sync_flag_o);
   // R7
   sw_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_force_i && sync_sel_i != 2'd0 && !sync_in_i && !sync_flag_o && !flag_clr_i)
      |=> !sync_flag_o);
   // R4
   zero_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && phase_en_i && sync_in_i && phase_i == '0) |=> (counter_o == '0));
   // R6
   sel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_sel_i == 2'd1 || sync_sel_i == 2'd3) |-> !sync_out_o);
endmodule

// File: tb/sim_pwm_timebase.sv
`timescale 1ns/1ps
module sim_pwm_timebase;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          run_i, phase_en_i, phase_dir_i, sw_force_i, sync_in_i, flag_clr_i;
   logic [CW-1:0] period_i, phase_i, cmpb_i;
   logic [1:0]    sync_sel_i;
   logic [CW-1:0] counter_o;
   logic          dir_down_o, sync_flag_o, sync_out_o;

   int  n_chk = 0;
   int  n_err = 0;
   bit  cmp_on = 1'b0;
   bit  done = 1'b0;

   // behavioural reference state
   int  m_cnt = 0, m_prd = 0, m_dir = 0, m_flag = 0, m_hit = 0;

   always #2.5 clk = ~clk;

   pwm_timebase #(.CW(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .run_i(run_i), .period_i(period_i),
      .phase_i(phase_i), .phase_en_i(phase_en_i), .phase_dir_i(phase_dir_i),
      .cmpb_i(cmpb_i), .sync_sel_i(sync_sel_i), .sw_force_i(sw_force_i),
      .sync_in_i(sync_in_i), .flag_clr_i(flag_clr_i), .counter_o(counter_o),
      .dir_down_o(dir_down_o), .sync_flag_o(sync_flag_o), .sync_out_o(sync_out_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
      #1;
   endtask

   always @(posedge clk) begin
      int evt, pe, v, nxt_cnt, nxt_dir;
      if (!rst_n) begin
         m_cnt = 0; m_prd = 0; m_dir = 0; m_flag = 0; m_hit = 0;
      end else begin
         evt = (sync_in_i || (sw_force_i && sync_sel_i == 2'd0)) ? 1 : 0;
         pe  = (m_cnt == 0) ? int'(period_i) : m_prd;
         m_hit = (run_i && m_cnt == int'(cmpb_i)) ? 1 : 0;
         if (evt != 0)      m_flag = 1;
         else if (flag_clr_i) m_flag = 0;
         nxt_cnt = m_cnt;
         nxt_dir = m_dir;
         if (run_i) begin
            if (phase_en_i && evt != 0) begin
               v = (int'(phase_i) > pe) ? pe : int'(phase_i);
               nxt_cnt = v;
               nxt_dir = (v == pe) ? 1 : (v == 0) ? 0 : int'(phase_dir_i);
            end else if (pe == 0) begin
               nxt_cnt = 0;
            end else if (m_dir == 0) begin
               if (m_cnt >= pe) begin nxt_dir = 1; nxt_cnt = m_cnt - 1; end
               else nxt_cnt = m_cnt + 1;
            end else begin
               if (m_cnt == 0) begin nxt_dir = 0; nxt_cnt = 1; end
               else nxt_cnt = m_cnt - 1;
            end
         end
         if (m_cnt == 0) m_prd = int'(period_i);
         m_cnt = nxt_cnt;
         m_dir = nxt_dir;
      end
   end

   always @(negedge clk) begin
      int exp_so;
      if (cmp_on) begin
         exp_so = (sync_sel_i == 2'd0) ? int'(sync_in_i | sw_force_i) :
                  (sync_sel_i == 2'd2) ? m_hit : 0;
         chk("R2 counter", int'(counter_o), m_cnt);
         chk("R5 direction", int'(dir_down_o), m_dir);
         chk("R8 flag", int'(sync_flag_o), m_flag);
         chk("R6 sync_out", int'(sync_out_o), exp_so);
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_err++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      int mx, pulses, v, d;
      rst_n = 1'b0; run_i = 1'b0; phase_en_i = 1'b0; phase_dir_i = 1'b0;
      sw_force_i = 1'b0; sync_in_i = 1'b0; flag_clr_i = 1'b0;
      period_i = '0; phase_i = '0; cmpb_i = '0; sync_sel_i = 2'd2;
      repeat (3) cyc();
      // R1 reset state
      chk("R1 counter", int'(counter_o), 0);
      chk("R1 dir", int'(dir_down_o), 0);
      chk("R1 flag", int'(sync_flag_o), 0);
      chk("R1 sync_out", int'(sync_out_o), 0);
      rst_n = 1'b1; cmp_on = 1'b1;

      // R2 triangle peak
      period_i = 16'd6; run_i = 1'b1; mx = 0;
      repeat (20) begin cyc(); if (int'(counter_o) > mx) mx = int'(counter_o); end
      chk("R2 peak", mx, 6);

      // R3 freeze
      run_i = 1'b0; cyc(); v = int'(counter_o); d = int'(dir_down_o);
      repeat (5) cyc();
      chk("R3 counter held", int'(counter_o), v);
      chk("R3 dir held", int'(dir_down_o), d);
      run_i = 1'b1;

      // R4 phase load
      sync_sel_i = 2'd0; phase_en_i = 1'b1; phase_i = 16'd3; phase_dir_i = 1'b0;
      sync_in_i = 1'b1; cyc(); sync_in_i = 1'b0;
      chk("R4 loaded", int'(counter_o), 3);
      chk("R5 dir after load", int'(dir_down_o), 0);
      cyc();
      chk("R4 continues", int'(counter_o), 4);
      phase_en_i = 1'b0; sync_in_i = 1'b1; cyc(); sync_in_i = 1'b0;
      chk("R4 no load when disabled", int'(counter_o), 5);

      // R5 clamp and direction
      phase_en_i = 1'b1; phase_i = 16'd10; sync_in_i = 1'b1; cyc(); sync_in_i = 1'b0;
      chk("R5 clamped", int'(counter_o), 6);
      chk("R5 forced down", int'(dir_down_o), 1);
      cyc();
      chk("R5 after clamp", int'(counter_o), 5);
      phase_i = 16'd2; phase_dir_i = 1'b1; sync_in_i = 1'b1; cyc(); sync_in_i = 1'b0;
      chk("R5 down load", int'(counter_o), 2);
      cyc();
      chk("R5 continues down", int'(counter_o), 1);
      phase_dir_i = 1'b0; sync_in_i = 1'b1; cyc(); sync_in_i = 1'b0;
      cyc();
      chk("R5 continues up", int'(counter_o), 3);

      // R6 compare pulses and select codes
      phase_en_i = 1'b0; cmpb_i = 16'd3; sync_sel_i = 2'd2; pulses = 0;
      repeat (12) begin cyc(); pulses += int'(sync_out_o); end
      chk("R6 pulses per cycle", pulses, 2);
      sync_sel_i = 2'd1; sync_in_i = 1'b1; #1;
      chk("R6 sel1 low", int'(sync_out_o), 0);
      sync_sel_i = 2'd0; #1;
      chk("R6 pass-through", int'(sync_out_o), 1);
      cyc(); sync_in_i = 1'b0;

      // R7 software force ignored outside pass-through
      flag_clr_i = 1'b1; cyc(); flag_clr_i = 1'b0;
      chk("R8 cleared", int'(sync_flag_o), 0);
      sync_sel_i = 2'd2; phase_en_i = 1'b1; phase_i = 16'd1; sw_force_i = 1'b1;
      cyc(); sw_force_i = 1'b0;
      chk("R7 no flag", int'(sync_flag_o), 0);
      chk("R7 no load", int'(counter_o), m_cnt);

      // R8 sticky flag, set wins over clear
      run_i = 1'b0; phase_en_i = 1'b0; sync_in_i = 1'b1; cyc(); sync_in_i = 1'b0;
      chk("R8 set while stopped", int'(sync_flag_o), 1);
      cyc();
      chk("R8 sticky", int'(sync_flag_o), 1);
      flag_clr_i = 1'b1; sync_in_i = 1'b1; cyc(); sync_in_i = 1'b0;
      chk("R8 set wins", int'(sync_flag_o), 1);
      cyc(); flag_clr_i = 1'b0;
      chk("R8 clear", int'(sync_flag_o), 0);
      run_i = 1'b1;

      // R9 period captured only at zero
      for (int i = 0; i < 20 && counter_o != '0; i++) cyc();
      cyc(); cyc();
      period_i = 16'd2; mx = 0;
      for (int i = 0; i < 20 && counter_o != '0; i++) begin
         cyc(); if (int'(counter_o) > mx) mx = int'(counter_o);
      end
      chk("R9 old peak kept", mx, 6);
      mx = 0;
      repeat (6) begin cyc(); if (int'(counter_o) > mx) mx = int'(counter_o); end
      chk("R9 new peak", mx, 2);

      // R10 software force latency
      period_i = 16'd6;
      for (int i = 0; i < 20 && counter_o != '0; i++) cyc();
      cyc();
      sync_sel_i = 2'd0; phase_en_i = 1'b1; phase_i = 16'd5; sw_force_i = 1'b1;
      cyc(); sw_force_i = 1'b0;
      chk("R10 counter latency", int'(counter_o), 5);
      chk("R10 flag latency", int'(sync_flag_o), 1);

      // random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         cyc();
         run_i       = ($urandom % 8) != 0;
         sync_in_i   = ($urandom % 12) == 0;
         sw_force_i  = ($urandom % 12) == 0;
         sync_sel_i  = 2'($urandom % 4);
         phase_en_i  = 1'($urandom % 2);
         phase_dir_i = 1'($urandom % 2);
         phase_i     = 16'($urandom % 16);
         cmpb_i      = 16'($urandom % 13);
         flag_clr_i  = ($urandom % 6) == 0;
         if (($urandom % 40) == 0) period_i = 16'($urandom % 13);
      end
      cyc();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule